// File: doc/BRIEF.md
# Codec Control-Register Write Master (I2C)

This block programs one control register of a stereo audio codec per request by issuing a write-only transaction on a two-wire I2C bus. A host places a 7-bit register index, a 9-bit register value, a 16-bit clock prescaler and the level of the codec's address-select strap on the inputs, then pulses a start strobe. The block then performs the whole write without further help: start condition, device address with the write bit, two payload bytes, and stop condition. It checks the acknowledge bit that follows every byte.

The codec's register word is 16 bits: the index fills the upper seven bits and the 9-bit value fills the rest. As a result, value bit 8 lands in the least significant position of the first payload byte. The codec holds eleven such registers (indices 0 to 10), and the host walks its own initialization list one write at a time. The bus lines are open-drain: the block only ever pulls SCL or SDA low through enable outputs and otherwise releases them. Status is reported by a busy level, a one-cycle done pulse, and an error flag.

Top module: `codec_cfg_i2c`

## Requirements
- R1: After a synchronous active-low reset, both bus lines are released (`scl_oe_o`=0, `sda_oe_o`=0) and `busy_o`, `done_o` and `err_o` are 0.
- R2: The first byte on the bus is the device address followed by a 0 write bit: 0x34 (address 0011010) when `addr_sel_i` is 0 and 0x36 (address 0011011) when it is 1.
- R3: The second byte is {index[6:0], value[8]} and the third byte is value[7:0]. Every byte is sent most significant bit first.
- R4: Each transaction opens with exactly one start condition (SDA falls while SCL is high) and closes with exactly one stop condition (SDA rises while SCL is high).
- R5: Apart from the start and stop conditions, SDA changes only while SCL is low.
- R6: The SCL period is 2×(P+1) system clocks, where P is `prescale_i` latched at the accepted start. A latched value of 0 is used as 1, which gives a period of 4 clocks.
- R7: If SDA reads high on the ninth clock of any byte, the block sets `err_o`, sends no further byte, and issues a stop condition before returning to idle.
- R8: `busy_o` rises one clock after an accepted start and stays high until the transaction ends. A start strobe seen while busy is ignored and does not change the bytes being sent.
- R9: `done_o` is a single-cycle pulse at the end of every transaction, whether it succeeded or failed. `err_o` keeps its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Strobe requesting one register write |
| addr_sel_i | input | 1 | Codec address-select strap level |
| reg_idx_i | input | 7 | Codec register index |
| reg_val_i | input | 9 | Codec register value |
| prescale_i | input | 16 | SCL half-period minus one, in system clocks |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at transaction end |
| err_o | output | 1 | Missing acknowledge seen in the last transaction |

## Verification
The assertions check the following on every cycle:
- the reset state of the outputs;
- that SDA holds steady during every SCL-high data phase;
- that SDA edges while SCL is high occur only as start or stop;
- that the half-period counter never passes the latched prescaler;
- that busy can only follow a strobe, that done is a one-cycle pulse, and that the error flag can only follow a high acknowledge sample.

Only the bench scenarios can show the rest. Those scenarios are: the exact byte contents for both strap levels and for several index/value patterns, the measured SCL period for several prescaler values including 0, the early stop after a missing acknowledge on the address byte and on the last byte, and that a strobe arriving mid-transfer leaves the transfer intact.

// File: rtl/cfg_i2c_pkg.sv
// Shared types for the codec register write master.
// Assumes a 7-bit index plus a 9-bit value form one 16-bit codec word.
package cfg_i2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BLO,
        ST_BHI,
        ST_PLO,
        ST_PHI,
        ST_PEND
    } cfg_state_e;

    localparam logic [5:0] DEV_ADDR_HI = 6'b001101;
endpackage

// File: rtl/codec_i2c_halfclk.sv
// Half-period timer: counts system clocks while running and flags the last
// clock of each half SCL period. Assumes limit is held stable while running.
module codec_i2c_halfclk #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick,
    output logic [W-1:0] cnt
);
    assign tick = run && (cnt == limit);

    // Count up within a half period, wrap on tick, hold at 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/codec_i2c_frame.sv
// Builds the three-byte write frame: device address with write bit, then the
// 16-bit codec word {index, value}. Assumes IDX_W + VAL_W = 16.
module codec_i2c_frame #(
    parameter int IDX_W = 7,
    parameter int VAL_W = 9,
    localparam int FRAME_W = 8 + IDX_W + VAL_W
) (
    input  logic               addr_sel,
    input  logic [IDX_W-1:0]   idx,
    input  logic [VAL_W-1:0]   val,
    output logic [FRAME_W-1:0] frame
);
    // Address byte, then index in the top bits with value bit 8 below it.
    assign frame = {cfg_i2c_pkg::DEV_ADDR_HI, addr_sel, 1'b0, idx, val};
endmodule

// File: rtl/codec_cfg_i2c.sv
// Codec register write master: one strobe sends one complete I2C write of
// address byte and two payload bytes, checking the acknowledge bit after each.
// Assumes no clock stretching, a single master, and open-drain lines resolved
// outside. SDA is updated one clock after SCL falls.
module codec_cfg_i2c
    import cfg_i2c_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int IDX_W = 7,
    parameter int VAL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             addr_sel_i,
    input  logic [IDX_W-1:0] reg_idx_i,
    input  logic [VAL_W-1:0] reg_val_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int FRAME_W = 8 + IDX_W + VAL_W;
    localparam int NBYTES  = FRAME_W / 8;
    localparam int BYTE_W  = $clog2(NBYTES);
    localparam logic [3:0]        ACK_BIT   = 4'd8;
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(NBYTES - 1);

    cfg_state_e         st_q;
    logic [FRAME_W-1:0] frame_d, frame_q;
    logic [PRE_W-1:0]   pre_q, half_cnt;
    logic [3:0]         bit_q;
    logic [BYTE_W-1:0]  byte_q;
    logic               tick, scl_q, sda_q, busy_q, done_q, err_q;

    codec_i2c_frame #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_frame (
        .addr_sel (addr_sel_i),
        .idx      (reg_idx_i),
        .val      (reg_val_i),
        .frame    (frame_d)
    );

    codec_i2c_halfclk #(.W(PRE_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q != ST_IDLE),
        .limit (pre_q),
        .tick  (tick),
        .cnt   (half_cnt)
    );

    // Transaction sequencer: one state per half SCL period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            frame_q <= '0;
            pre_q   <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            scl_q   <= 1'b0;
            sda_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    frame_q <= frame_d;
                    pre_q   <= (prescale_i == '0) ? PRE_W'(1) : prescale_i;
                    bit_q   <= '0;
                    byte_q  <= '0;
                    busy_q  <= 1'b1;
                    err_q   <= 1'b0;
                    sda_q   <= 1'b1;
                    st_q    <= ST_START;
                end
                ST_START: if (tick) begin
                    scl_q <= 1'b1;
                    st_q  <= ST_BLO;
                end
                ST_BLO: begin
                    if (half_cnt == '0)
                        sda_q <= (bit_q == ACK_BIT) ? 1'b0 : ~frame_q[FRAME_W-1];
                    if (tick) begin
                        scl_q <= 1'b0;
                        st_q  <= ST_BHI;
                    end
                end
                ST_BHI: if (tick) begin
                    scl_q <= 1'b1;
                    if (bit_q == ACK_BIT) begin
                        bit_q <= '0;
                        if (sda_i) begin
                            err_q <= 1'b1;
                            st_q  <= ST_PLO;
                        end else if (byte_q == LAST_BYTE) begin
                            st_q <= ST_PLO;
                        end else begin
                            byte_q <= byte_q + 1'b1;
                            st_q   <= ST_BLO;
                        end
                    end else begin
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                        st_q    <= ST_BLO;
                    end
                end
                ST_PLO: begin
                    if (half_cnt == '0) sda_q <= 1'b1;
                    if (tick) begin
                        scl_q <= 1'b0;
                        st_q  <= ST_PHI;
                    end
                end
                ST_PHI: if (tick) begin
                    sda_q <= 1'b0;
                    st_q  <= ST_PEND;
                end
                ST_PEND: if (tick) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign scl_oe_o = scl_q;
    assign sda_oe_o = sda_q;
    assign busy_o   = busy_q;
    assign done_o   = done_q;
    assign err_o    = err_q;
endmodule

// File: rtl/codec_cfg_i2c_chk.sv
// Protocol checker for the codec register write master, bound to the top.
// Assumes the internal state, half counter and latched prescaler are visible.
module codec_cfg_i2c_chk
    import cfg_i2c_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sda_i,
    input logic             scl_oe_o,
    input logic             sda_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input cfg_state_e       st,
    input logic [PRE_W-1:0] cnt,
    input logic [PRE_W-1:0] pre
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!scl_oe_o && !sda_oe_o && !busy_o && !done_o && !err_o)); // R1

    AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && !scl_oe_o) |-> st == ST_START); // R4

    AST_STOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe_o) && !scl_oe_o) |-> st == ST_PEND); // R4

    AST_SDA_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BHI && $past(st) == ST_BHI) |-> $stable(sda_oe_o)); // R5

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (cnt <= pre && pre != '0)); // R6

    AST_NACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(st) == ST_BHI && $past(sda_i))); // R7

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

bind codec_cfg_i2c codec_cfg_i2c_chk #(.PRE_W(PRE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sda_i    (sda_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .st       (st_q),
    .cnt      (half_cnt),
    .pre      (pre_q)
);

// File: tb/codec_cfg_i2c_bench.sv
// Bench: vector table of writes, then directed reset, NACK and busy cases.
module codec_cfg_i2c_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        addr_sel_i = 1'b0;
    logic [6:0]  reg_idx_i = '0;
    logic [8:0]  reg_val_i = '0;
    logic [15:0] prescale_i = '0;
    logic        scl_oe_o, sda_oe_o, busy_o, done_o, err_o;
    logic        slave_pull = 1'b0;
    logic        scl_line, sda_line;

    assign scl_line = ~scl_oe_o;
    assign sda_line = ~(sda_oe_o | slave_pull);

    codec_cfg_i2c u_codec_cfg_i2c (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_sel_i(addr_sel_i),
        .reg_idx_i(reg_idx_i), .reg_val_i(reg_val_i), .prescale_i(prescale_i),
        .sda_i(sda_line), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int fails = 0;

    // Slave model state; nack_mask bit n refuses byte n.
    int         cyc = 0, nbits = 0, nbytes = 0, starts = 0, stops = 0, nrise = 0;
    int         rise0 = 0, rise1 = 0;
    logic [7:0] cur = '0;
    logic [7:0] rx [0:3];
    logic [3:0] nack_mask = '0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;

    // Slave: samples the lines between clock edges, decodes and acknowledges.
    initial forever begin
        @(negedge clk);
        cyc++;
        if (prev_scl && scl_line && prev_sda && !sda_line) begin
            starts++; nbits = 0;
        end
        if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
        if (!prev_scl && scl_line) begin
            if (nrise == 0) rise0 = cyc;
            if (nrise == 1) rise1 = cyc;
            nrise++;
            if (nbits < 8) begin
                cur = {cur[6:0], sda_line}; nbits++;
            end else begin
                if (nbytes < 4) rx[nbytes] = cur;
                nbytes++; nbits = 0;
            end
        end
        if (prev_scl && !scl_line)
            slave_pull = (nbits == 8) && !nack_mask[nbytes % 4];
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic sel, input logic [6:0] idx, input logic [8:0] val,
                          input logic [15:0] pre, input logic [3:0] mask);
        @(negedge clk);
        nbytes = 0; starts = 0; stops = 0; nrise = 0; nack_mask = mask;
        addr_sel_i = sel; reg_idx_i = idx; reg_val_i = val; prescale_i = pre;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    endtask

    task automatic finish_xfer(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        chk(seen, "R9 done seen", seen, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        chk(busy_o == 1'b0, "R8 busy cleared", busy_o, 0);
        chk(stops == 1, "R4 one stop", stops, 1);
        chk(starts == 1, "R4 one start", starts, 1);
    endtask

    function automatic logic [7:0] addr_byte(input logic sel);
        return {6'b001101, sel, 1'b0};
    endfunction

    // {sel, index, value, prescaler}
    localparam logic [32:0] VEC [0:4] = '{
        {1'b0, 7'h00, 9'h017, 16'd1},
        {1'b1, 7'h04, 9'h1A5, 16'd2},
        {1'b0, 7'h07, 9'h043, 16'd0},
        {1'b1, 7'h09, 9'h001, 16'd3},
        {1'b0, 7'h0A, 9'h1FF, 16'd1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit seen;
        rx[0] = '0; rx[1] = '0; rx[2] = '0; rx[3] = '0;
        repeat (3) @(negedge clk);
        chk(!scl_oe_o && !sda_oe_o, "R1 lines released", {scl_oe_o, sda_oe_o}, 0);
        chk(!busy_o && !done_o && !err_o, "R1 status clear", {busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 5; v++) begin
            logic        s;
            logic [6:0]  ix;
            logic [8:0]  vl;
            logic [15:0] pr;
            int          per;
            {s, ix, vl, pr} = VEC[v];
            launch(s, ix, vl, pr, 4'b0000);
            finish_xfer(seen);
            per = 2 * (((pr == 0) ? 1 : int'(pr)) + 1);
            chk(nbytes == 3, "R3 byte count", nbytes, 3);
            chk(rx[0] == addr_byte(s), "R2 address byte", rx[0], addr_byte(s));
            chk(rx[1] == {ix, vl[8]}, "R3 first payload", rx[1], {ix, vl[8]});
            chk(rx[2] == vl[7:0], "R3 second payload", rx[2], vl[7:0]);
            chk(rise1 - rise0 == per, "R6 scl period", rise1 - rise0, per);
            chk(err_o == 1'b0, "R9 no error", err_o, 0);
        end

        // R7: refused address byte ends early with stop and error.
        launch(1'b1, 7'h03, 9'h155, 16'd1, 4'b0001);
        finish_xfer(seen);
        chk(err_o == 1'b1, "R7 nack address err", err_o, 1);
        chk(nbytes == 1, "R7 nack address bytes", nbytes, 1);

        // R7: refused last byte.
        launch(1'b0, 7'h05, 9'h0AA, 16'd2, 4'b0100);
        finish_xfer(seen);
        chk(err_o == 1'b1, "R7 nack last err", err_o, 1);
        chk(nbytes == 3, "R7 nack last bytes", nbytes, 3);

        // R9: error stays until next start, then cleared.
        repeat (5) @(negedge clk);
        chk(err_o == 1'b1, "R9 error held", err_o, 1);
        // R8: strobe during busy is ignored.
        launch(1'b0, 7'h02, 9'h0F0, 16'd1, 4'b0000);
        chk(err_o == 1'b0, "R9 error cleared", err_o, 0);
        repeat (20) @(negedge clk);
        addr_sel_i = 1'b1; reg_idx_i = 7'h06; reg_val_i = 9'h10F; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        finish_xfer(seen);
        chk(rx[0] == addr_byte(1'b0), "R8 ignored start addr", rx[0], addr_byte(1'b0));
        chk(rx[1] == {7'h02, 1'b0}, "R8 ignored start byte1", rx[1], {7'h02, 1'b0});
        chk(rx[2] == 8'hF0, "R8 ignored start byte2", rx[2], 8'hF0);
        repeat (10) @(negedge clk);
        chk(busy_o == 1'b0, "R8 no second transfer", busy_o, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule